// File: doc/BRIEF.md
# Debug Communication Mailbox

This block passes 32-bit words both ways between the processor and an external debug probe. It holds two one-word slots. The outbound slot is written by the processor and read by the probe. The inbound slot is written by the probe and read by the processor. Each slot has a full flag and an overrun flag. Software can poll these flags through a status word that both sides can read.

Polling is optional. The block keeps two sticky pending bits: one is set when the probe deposits an inbound word, the other when the probe takes the outbound word. Each pending bit has its own enable. The interrupt line is the OR of the pending bits whose enable is set, and it goes to an external interrupt controller.

Both register buses are plain single-cycle access ports. An access is a cycle with the select input high. Read data is combinational from the current state and is valid in the same cycle as the select. Neither port has back-pressure: every access is accepted at the clock edge that ends it. This lets the probe reach the mailbox at any time while the processor runs.

Top module: `dbgmb_top`

## Requirements
- R1: After reset both slots hold 0, every full, overrun, pending and enable bit is 0, and `irq` is low.
- R2: A processor write to address 0 loads the outbound slot and sets its full flag (status bit 0). A probe read of address 0 returns the slot and clears the full flag.
- R3: A probe write to address 1 loads the inbound slot and sets its full flag (status bit 2). A processor read of address 1 returns the slot and clears the full flag.
- R4: A write to a slot that is still full overwrites the word and sets that slot's overrun flag (status bit 1 outbound, bit 3 inbound). A read by the far side clears both full and overrun. A write and a far-side read in the same cycle leave full set and overrun clear.
- R5: A probe write of the inbound slot sets pending bit 4 of the control word. Any probe read of the outbound slot sets pending bit 5. Both happen whatever the enables are.
- R6: A processor write to the control word (address 3) loads the enables from bits 1:0 (bit 0 for the inbound-write source, bit 1 for the outbound-read source) and clears each pending bit whose position (4 or 5) is written as 1. A new event in the same cycle wins over the clear.
- R7: `irq` is high exactly when some pending bit has its enable set. It follows the state one clock after the event or the control write.
- R8: Address 2 reads the status word {rx_ovr, rx_full, tx_ovr, tx_full} in bits 3:0 on both ports. A probe read of address 3 returns 0. These accesses have no effect: processor writes to addresses 1 or 2, probe writes to addresses 0, 2 or 3, and reads other than the consuming ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 2 | Processor register address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, same cycle |
| dbg_sel | input | 1 | Probe access strobe |
| dbg_we | input | 1 | Probe write (1) or read (0) |
| dbg_addr | input | 2 | Probe register address |
| dbg_wdata | input | 32 | Probe write data |
| dbg_rdata | output | 32 | Probe read data, same cycle |
| irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
Any wrong flag shows up on the next status read from either port, one clock after the access that caused it. A wrong pending or enable bit shows up on `irq` at that same clock, so the line is compared on every cycle. The sweep covers every enable setting against every ordered mix of the four data accesses, checking the status, control word and `irq` after each one. This catches a lost or stray full, overrun or pending bit within one cycle. Directed cycles cover the two collisions, write against read and event against clear, where a wrong priority would leave a flag one state off.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_TX   = 2'd0;
  localparam logic [REG_AW-1:0] A_RX   = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT = 2'd2;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd3;
  localparam int N_SRC    = 2;  // 0: inbound written, 1: outbound consumed
  localparam int PEND_LSB = 4;

  typedef struct packed {
    logic ovr;
    logic full;
  } slot_flags_t;
endpackage

// File: rtl/dbgmb_slot.sv
module dbgmb_slot #(
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [DW-1:0]            wdata,
  input  logic                     cons,
  output logic [DW-1:0]            data,
  output dbgmb_pkg::slot_flags_t   flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      flags <= '0;
    end else begin
      if (wr) data <= wdata;
      flags.full <= wr | (flags.full & ~cons);
      flags.ovr  <= ~cons & (flags.ovr | (wr & flags.full));
    end
  end
endmodule

// File: rtl/dbgmb_irq.sv
module dbgmb_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] set,
  output logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]   <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        if (ctl_we) en[i] <= en_wdata[i];
        pend[i] <= set[i] | (pend[i] & ~(ctl_we & clr_mask[i]));
      end
    end
  end

  assign irq = |(pend & en);
endmodule

// File: rtl/dbgmb_top.sv
module dbgmb_top #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dbg_sel,
  input  logic          dbg_we,
  input  logic [1:0]    dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          irq
);
  import dbgmb_pkg::*;

  localparam int STAT_W = 4;

  logic tx_wr, tx_cons, rx_wr, rx_cons, ctl_we;
  logic [DW-1:0] tx_data, rx_data;
  slot_flags_t   tx_flags, rx_flags;
  logic [N_SRC-1:0] en, pend;
  logic [DW-1:0] stat_word, ctrl_word;

  assign tx_wr   = cpu_sel &  cpu_we & (cpu_addr == A_TX);
  assign rx_cons = cpu_sel & ~cpu_we & (cpu_addr == A_RX);
  assign ctl_we  = cpu_sel &  cpu_we & (cpu_addr == A_CTRL);
  assign rx_wr   = dbg_sel &  dbg_we & (dbg_addr == A_RX);
  assign tx_cons = dbg_sel & ~dbg_we & (dbg_addr == A_TX);

  dbgmb_slot #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(cpu_wdata),
    .cons(tx_cons), .data(tx_data), .flags(tx_flags)
  );

  dbgmb_slot #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .wr(rx_wr), .wdata(dbg_wdata),
    .cons(rx_cons), .data(rx_data), .flags(rx_flags)
  );

  dbgmb_irq #(.N(N_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .en_wdata(cpu_wdata[N_SRC-1:0]),
    .clr_mask(cpu_wdata[PEND_LSB +: N_SRC]),
    .set({tx_cons, rx_wr}),
    .en(en), .pend(pend), .irq(irq)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_W-1:0] = {rx_flags.ovr, rx_flags.full, tx_flags.ovr, tx_flags.full};
    ctrl_word = '0;
    ctrl_word[N_SRC-1:0] = en;
    ctrl_word[PEND_LSB +: N_SRC] = pend;
  end

  always_comb begin
    unique case (cpu_addr)
      A_TX:    cpu_rdata = tx_data;
      A_RX:    cpu_rdata = rx_data;
      A_STAT:  cpu_rdata = stat_word;
      default: cpu_rdata = ctrl_word;
    endcase
  end

  always_comb begin
    unique case (dbg_addr)
      A_TX:    dbg_rdata = tx_data;
      A_RX:    dbg_rdata = rx_data;
      A_STAT:  dbg_rdata = stat_word;
      default: dbg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgmb_chk.sv
module dbgmb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_sel,
  input logic       cpu_we,
  input logic [1:0] cpu_addr,
  input logic       dbg_sel,
  input logic       dbg_we,
  input logic [1:0] dbg_addr,
  input logic       tx_full,
  input logic       tx_ovr,
  input logic       rx_full,
  input logic [1:0] pend,
  input logic       irq
);
  logic p_rxw, p_txr, p_txw, p_ctl;
  assign p_rxw = dbg_sel &  dbg_we & (dbg_addr == 2'd1);
  assign p_txr = dbg_sel & ~dbg_we & (dbg_addr == 2'd0);
  assign p_txw = cpu_sel &  cpu_we & (cpu_addr == 2'd0);
  assign p_ctl = cpu_sel &  cpu_we & (cpu_addr == 2'd3);

  a_r3_rx_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    p_rxw |=> rx_full);
  a_r2_tx_empty_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (p_txr && !p_txw) |=> !tx_full);
  a_r4_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovr |-> tx_full);
  a_r5_pend_on_rx_write: assert property (@(posedge clk) disable iff (!rst_n)
    p_rxw |=> pend[0]);
  a_r5_pend_on_tx_read: assert property (@(posedge clk) disable iff (!rst_n)
    p_txr |=> pend[1]);
  a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(p_rxw || p_txr || p_ctl));
endmodule

bind dbgmb_top dbgmb_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
  .tx_full(tx_flags.full), .tx_ovr(tx_flags.ovr), .rx_full(rx_flags.full),
  .pend(pend), .irq(irq)
);

// File: tb/dbgmb_top_tb.sv
module dbgmb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_sel = 0, cpu_we = 0, dbg_sel = 0, dbg_we = 0;
  logic [1:0] cpu_addr = 0, dbg_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, dbg_wdata = 0, cpu_rdata, dbg_rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgmb_top #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .irq(irq)
  );

  // bench model of the requirements
  logic [DW-1:0] m_txd = 0, m_rxd = 0;
  logic m_txf = 0, m_txo = 0, m_rxf = 0, m_rxo = 0;
  logic [1:0] m_en = 0, m_pend = 0;

  function automatic logic [DW-1:0] m_stat();
    return {28'd0, m_rxo, m_rxf, m_txo, m_txf};
  endfunction

  task automatic cmp(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag,
                     input logic cs, input logic cw, input logic [1:0] ca, input logic [DW-1:0] cd,
                     input logic ds, input logic dw, input logic [1:0] da, input logic [DW-1:0] dd);
    logic txw, txc, rxw, rxc, ctw;
    logic [DW-1:0] ec, ed;
    @(negedge clk);
    cpu_sel = cs; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    dbg_sel = ds; dbg_we = dw; dbg_addr = da; dbg_wdata = dd;
    #1;
    case (ca)
      2'd0: ec = m_txd;
      2'd1: ec = m_rxd;
      2'd2: ec = m_stat();
      default: ec = {26'd0, m_pend, 2'b00, m_en};
    endcase
    case (da)
      2'd0: ed = m_txd;
      2'd1: ed = m_rxd;
      2'd2: ed = m_stat();
      default: ed = '0;
    endcase
    if (cs && !cw) cmp({tag, " cpu read"}, cpu_rdata, ec);
    if (ds && !dw) cmp({tag, " dbg read"}, dbg_rdata, ed);
    txw = cs & cw & (ca == 2'd0);
    rxc = cs & !cw & (ca == 2'd1);
    ctw = cs & cw & (ca == 2'd3);
    rxw = ds & dw & (da == 2'd1);
    txc = ds & !dw & (da == 2'd0);
    m_txo = !txc & (m_txo | (txw & m_txf));
    m_txf = txw | (m_txf & !txc);
    if (txw) m_txd = cd;
    m_rxo = !rxc & (m_rxo | (rxw & m_rxf));
    m_rxf = rxw | (m_rxf & !rxc);
    if (rxw) m_rxd = dd;
    m_pend[0] = rxw | (m_pend[0] & !(ctw & cd[4]));
    m_pend[1] = txc | (m_pend[1] & !(ctw & cd[5]));
    if (ctw) m_en = cd[1:0];
    @(posedge clk);
    #1;
    cpu_sel = 0; dbg_sel = 0;
    cmp("R7 irq", {31'd0, irq}, {31'd0, |(m_en & m_pend)});
  endtask

  task automatic cpu_op(string t, logic w, logic [1:0] a, logic [DW-1:0] d);
    cyc(t, 1, w, a, d, 0, 0, 0, 0);
  endtask
  task automatic dbg_op(string t, logic w, logic [1:0] a, logic [DW-1:0] d);
    cyc(t, 0, 0, 0, 0, 1, w, a, d);
  endtask
  task automatic peek(string t);
    cpu_op({t, " R8 status"}, 0, 2'd2, 0);
    cpu_op({t, " R6 ctrl"}, 0, 2'd3, 0);
    dbg_op({t, " R8 dbg status"}, 0, 2'd2, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 irq after reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    peek("R1");
    cpu_op("R1 tx word", 0, 2'd0, 0);
    cpu_op("R1 rx word", 0, 2'd1, 0);

    // sweep: every enable pair against every mix of the four data accesses
    for (int en = 0; en < 4; en++) begin
      for (int pat = 0; pat < 16; pat++) begin
        cpu_op("R6 set enables, clear pending", 1, 2'd3, 32'h30 | en);
        if (pat[0]) cpu_op("R2 cpu write tx", 1, 2'd0, 32'hA500_0000 + en*256 + pat);
        if (pat[1]) dbg_op("R3 dbg write rx", 1, 2'd1, 32'h5A00_0000 + en*256 + pat);
        peek("R5 after writes");
        if (pat[2]) dbg_op("R2 dbg read tx", 0, 2'd0, 0);
        if (pat[3]) cpu_op("R3 cpu read rx", 0, 2'd1, 0);
        peek("R7 after reads");
      end
    end

    // R4 overrun on both slots, cleared by far-side read
    cpu_op("R4 tx first", 1, 2'd0, 32'h1111_1111);
    cpu_op("R4 tx second", 1, 2'd0, 32'h2222_2222);
    dbg_op("R4 dbg write rx 1", 1, 2'd1, 32'h3333_3333);
    dbg_op("R4 dbg write rx 2", 1, 2'd1, 32'h4444_4444);
    peek("R4 overrun set");
    dbg_op("R4 dbg read overwritten tx", 0, 2'd0, 0);
    cpu_op("R4 cpu read overwritten rx", 0, 2'd1, 0);
    peek("R4 overrun cleared");
    // R4 same-cycle write and read
    cpu_op("R4 tx fill", 1, 2'd0, 32'h5555_5555);
    cyc("R4 tx collide", 1, 1, 2'd0, 32'h6666_6666, 1, 0, 2'd0, 0);
    peek("R4 after collide");
    dbg_op("R4 dbg read new word", 0, 2'd0, 0);
    dbg_op("R4 rx fill", 1, 2'd1, 32'h7777_7777);
    cyc("R4 rx collide", 1, 0, 2'd1, 0, 1, 1, 2'd1, 32'h8888_8888);
    peek("R4 after rx collide");
    cpu_op("R4 cpu read new rx", 0, 2'd1, 0);

    // R6 event wins over same-cycle clear
    cpu_op("R6 enable both", 1, 2'd3, 32'h33);
    cyc("R6 rx event vs clear", 1, 1, 2'd3, 32'h13, 1, 1, 2'd1, 32'h9999_0000);
    cyc("R6 tx event vs clear", 1, 1, 2'd3, 32'h23, 1, 0, 2'd0, 0);
    peek("R6 pending kept");
    cpu_op("R6 clear only bit 4", 1, 2'd3, 32'h13);
    peek("R6 partial clear");
    cpu_op("R7 disable all", 1, 2'd3, 32'h00);
    peek("R7 masked");
    cpu_op("R6 clear all", 1, 2'd3, 32'h30);

    // R8 ignored accesses
    cpu_op("R3 drain rx", 0, 2'd1, 0);
    cpu_op("R8 cpu write rx addr", 1, 2'd1, 32'hDEAD_0001);
    cpu_op("R8 cpu write status", 1, 2'd2, 32'hF);
    dbg_op("R8 dbg write tx addr", 1, 2'd0, 32'hDEAD_0002);
    dbg_op("R8 dbg write status", 1, 2'd2, 32'hF);
    dbg_op("R8 dbg write ctrl", 1, 2'd3, 32'h33);
    dbg_op("R8 dbg read ctrl", 0, 2'd3, 0);
    dbg_op("R8 dbg read rx no consume", 0, 2'd1, 0);
    cpu_op("R8 cpu read tx no consume", 0, 2'd0, 0);
    peek("R8 nothing changed");
    cpu_op("R8 rx word kept", 0, 2'd1, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule